// File: doc/BRIEF.md
# Serial Data Test-Command Recognizer

This block sits on the byte stream that feeds an audio decoder's serial data input. Every byte goes through to the decoder unchanged. While bytes go by, the block looks for fixed eight-byte command sequences and acts on each one it finds. A tone command starts a built-in sine generator. The generator's sample rate and its number of samples per period both come from a single parameter byte. A quit command stops the tone. A memory-check command posts a self-test result word to header register 0 once a fixed wait has passed. A register-duplicate command reads a control register and writes its value into a header register.

The byte path is valid/ready. `in_ready` is the downstream `out_ready` passed straight through, so back-pressure reaches the source in the same cycle. A byte counts as taken only in a cycle where `in_valid` and `out_ready` are both high. A byte held while `out_ready` is low does not reach the matcher. Control-register reads use a plain address output with combinational read data. Header writes are a one-cycle write pulse with a select and a data word. Tone samples come out as a one-cycle strobe with a signed 16-bit value. The memory self-test is not built here: its result arrives on `mem_result`.

Top module: `tcr_recognizer`

## Requirements
- R1: `out_valid` equals `in_valid`, `out_data` equals `in_data` and `in_ready` equals `out_ready` in every cycle. Only bytes taken with `in_valid && out_ready` advance command matching.
- R2: Taking the eighth byte of 53 EF 6E n 00 00 00 00, with 48 ≤ n ≤ 119, raises `tone_active` from the next cycle on. If n is outside that range, the sequence has no effect.
- R3: The rate index is (n−48) mod 9. Indices 0..8 give 44100, 48000, 32000, 22050, 24000, 16000, 11025, 12000 and 8000 Hz. The period holds 8·((n−48) div 9 + 1) samples.
- R4: While the tone is on, the chosen rate is added to an accumulator on every clock. When the sum reaches CLK_HZ, `smp_valid` pulses for one cycle and CLK_HZ is subtracted. The accumulator starts from zero when the tone starts.
- R5: Sample i of a period of N samples (counted from 0, and the first sample after a start is i=0) carries round(32767·sin(2π·⌊64·i/N⌋/64)). The value is read from a 17-entry quarter-wave table.
- R6: Taking the eighth byte of 45 78 69 74 00 00 00 00 while the tone is on clears `tone_active` and stops the strobes from the next cycle. While the tone is on, every other command is ignored, and when the tone is off this sequence does nothing.
- R7: After 4D EA 6D 54 00 00 00 00, `hdr_we` pulses once, MEM_WAIT clock edges after the edge that took the last byte. On that pulse `hdr_sel` is 0 and `hdr_wdata` is `mem_result` as sampled at that edge.
- R8: After 53 70 EE n 00 00 00 00 with n < 2^REG_AW, `reg_addr` shows n from the next cycle. One cycle later `hdr_we` pulses with `hdr_wdata` = `reg_rdata`. `hdr_sel` is 1 when n equals HDR0_IDX and 0 otherwise. A larger n is ignored.
- R9: A byte that breaks a partial match restarts matching. The same byte is then checked again as a possible first byte.
- R10: While a memory check is waiting, any command that completes is discarded.
- R11: After reset, `tone_active`, `smp_valid`, `hdr_we`, `hdr_sel`, `hdr_wdata`, `smp_data` and `reg_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream byte valid |
| in_ready | output | 1 | Upstream ready (mirrors out_ready) |
| in_data | input | 8 | Upstream byte |
| out_valid | output | 1 | Downstream byte valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 8 | Downstream byte |
| reg_addr | output | REG_AW | Control register read address |
| reg_rdata | input | 16 | Control register read data (combinational) |
| mem_result | input | 16 | Self-test result word, 0 bits mean pass |
| hdr_we | output | 1 | Header register write pulse |
| hdr_sel | output | 1 | Header register select, 0 or 1 |
| hdr_wdata | output | 16 | Header register write data |
| tone_active | output | 1 | Sine test mode on |
| smp_valid | output | 1 | Tone sample strobe |
| smp_data | output | 16 | Signed tone sample |

## Verification
The command recognizer is exercised with clean sequences for each of the four commands. It also gets sequences broken by a repeated lead byte, which shows whether the restart re-checks the breaking byte. A byte held under back-pressure is put inside a tone command, which shows whether matching follows taken bytes only. Tone parameters n = 48, 62, 72 and 119 cover both ends of the range, a power-of-two period and a period that is not a power of two. The values 47 and 120 must be ignored. A memory check and a register copy are also sent while the tone is on, and a copy is sent while a memory check is waiting, so that ignored commands can be told apart from accepted ones.

// File: rtl/tcr_pkg.sv
package tcr_pkg;

  localparam int NCMD    = 4;
  localparam int SEQ_LEN = 8;
  localparam int SEQ_PW  = $clog2(SEQ_LEN);
  localparam logic [7:0] TONE_ARG_MIN = 8'd48;
  localparam logic [7:0] TONE_ARG_MAX = 8'd119;

  typedef enum logic [1:0] {
    CMD_TONE   = 2'd0,
    CMD_QUIT   = 2'd1,
    CMD_MEMCHK = 2'd2,
    CMD_REGDUP = 2'd3
  } cmd_e;

  // expected byte of command c at position p (parameter positions return 0)
  function automatic logic [7:0] seq_byte(input logic [1:0] c, input logic [SEQ_PW-1:0] p);
    logic [7:0] b;
    b = 8'h00;
    if (p < SEQ_PW'(4)) begin
      case ({c, p[1:0]})
        4'b0000: b = 8'h53;
        4'b0001: b = 8'hEF;
        4'b0010: b = 8'h6E;
        4'b0100: b = 8'h45;
        4'b0101: b = 8'h78;
        4'b0110: b = 8'h69;
        4'b0111: b = 8'h74;
        4'b1000: b = 8'h4D;
        4'b1001: b = 8'hEA;
        4'b1010: b = 8'h6D;
        4'b1011: b = 8'h54;
        4'b1100: b = 8'h53;
        4'b1101: b = 8'h70;
        4'b1110: b = 8'hEE;
        default: b = 8'h00;
      endcase
    end
    return b;
  endfunction

  // position that carries the free parameter byte
  function automatic logic seq_wild(input logic [1:0] c, input logic [SEQ_PW-1:0] p);
    return (p == SEQ_PW'(3)) && ((c == CMD_TONE) || (c == CMD_REGDUP));
  endfunction

  function automatic logic [15:0] rate_of(input logic [3:0] idx);
    logic [15:0] r;
    case (idx)
      4'd0:    r = 16'd44100;
      4'd1:    r = 16'd48000;
      4'd2:    r = 16'd32000;
      4'd3:    r = 16'd22050;
      4'd4:    r = 16'd24000;
      4'd5:    r = 16'd16000;
      4'd6:    r = 16'd11025;
      4'd7:    r = 16'd12000;
      default: r = 16'd8000;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tcr_seq_match.sv
module tcr_seq_match
  import tcr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [7:0]      din,
  input  logic [NCMD-1:0] allow,
  output logic            hit,
  output logic [1:0]      hit_cmd,
  output logic [7:0]      hit_arg
);

  localparam logic [SEQ_PW-1:0] LAST_POS = SEQ_PW'(SEQ_LEN - 1);
  localparam logic [SEQ_PW-1:0] ARG_POS  = SEQ_PW'(3);

  logic [SEQ_PW-1:0] pos;
  logic [NCMD-1:0]   cand;
  logic [7:0]        arg_q;
  logic [NCMD-1:0]   step_ok, head_ok, adv, first;

  for (genvar k = 0; k < NCMD; k++) begin : g_cmd
    assign step_ok[k] = seq_wild(2'(k), pos) || (din == seq_byte(2'(k), pos));
    assign head_ok[k] = (din == seq_byte(2'(k), '0));
  end

  assign adv   = cand & step_ok & allow;
  assign first = head_ok & allow;
  assign hit   = take && (pos == LAST_POS) && (adv != '0);
  assign hit_arg = arg_q;

  always_comb begin
    hit_cmd = 2'd0;
    for (int k = NCMD - 1; k >= 0; k--) begin
      if (adv[k]) hit_cmd = 2'(k);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= '0;
      cand  <= '0;
      arg_q <= '0;
    end else if (take) begin
      if (pos == '0) begin
        if (first != '0) begin
          pos  <= SEQ_PW'(1);
          cand <= first;
        end
      end else if (adv != '0) begin
        if (pos == LAST_POS) begin
          pos  <= '0;
          cand <= '0;
        end else begin
          pos  <= pos + SEQ_PW'(1);
          cand <= adv;
          if (pos == ARG_POS) arg_q <= din;
        end
      end else if (first != '0) begin
        pos  <= SEQ_PW'(1);
        cand <= first;
      end else begin
        pos  <= '0;
        cand <= '0;
      end
    end
  end

  AST_CAND_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pos != '0) |-> (cand != '0)); // R9

  AST_IDLE_NO_CAND: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == '0) |-> (cand == '0)); // R9

endmodule

// File: rtl/tcr_qsine.sv
module tcr_qsine (
  input  logic [5:0]  phase,
  output logic [15:0] value
);

  function automatic logic [14:0] quarter(input logic [4:0] a);
    logic [14:0] v;
    case (a)
      5'd0:  v = 15'd0;
      5'd1:  v = 15'd3212;
      5'd2:  v = 15'd6393;
      5'd3:  v = 15'd9512;
      5'd4:  v = 15'd12539;
      5'd5:  v = 15'd15446;
      5'd6:  v = 15'd18204;
      5'd7:  v = 15'd20787;
      5'd8:  v = 15'd23170;
      5'd9:  v = 15'd25329;
      5'd10: v = 15'd27245;
      5'd11: v = 15'd28898;
      5'd12: v = 15'd30273;
      5'd13: v = 15'd31356;
      5'd14: v = 15'd32137;
      5'd15: v = 15'd32609;
      default: v = 15'd32767;
    endcase
    return v;
  endfunction

  logic [4:0]  addr;
  logic [15:0] mag;

  always_comb begin
    addr = phase[4] ? (5'd16 - {1'b0, phase[3:0]}) : {1'b0, phase[3:0]};
    mag  = {1'b0, quarter(addr)};
    value = phase[5] ? (16'd0 - mag) : mag;
  end

endmodule

// File: rtl/tcr_tone.sv
module tcr_tone
  import tcr_pkg::*;
#(
  parameter int CLK_HZ = 24_576_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        stop,
  input  logic [7:0]  arg,
  output logic        active,
  output logic        smp_valid,
  output logic [15:0] smp_data
);

  localparam int AW = $clog2(CLK_HZ + 65536) + 1;

  logic [6:0]    off;
  logic [3:0]    fsi_n;
  logic [2:0]    k_n;
  logic [6:0]    ns_n;
  logic [3:0]    stepi_n;
  logic [5:0]    stepr_n;

  logic [15:0]   rate;
  logic [6:0]    nsamp;
  logic [3:0]    step_i;
  logic [5:0]    step_r;
  logic [5:0]    ph;
  logic [6:0]    rem;
  logic [AW-1:0] acc;

  logic [AW-1:0] sum;
  logic          wrap;
  logic [6:0]    rs;
  logic          carry;
  logic [15:0]   wave;

  assign off     = 7'(arg - TONE_ARG_MIN);
  assign fsi_n   = 4'(off % 7'd9);
  assign k_n     = 3'(off / 7'd9);
  assign ns_n    = (7'(k_n) + 7'd1) << 3;
  assign stepi_n = 4'(7'd64 / ns_n);
  assign stepr_n = 6'(7'd64 % ns_n);

  assign sum   = acc + AW'(rate);
  assign wrap  = sum >= AW'(CLK_HZ);
  assign rs    = rem + 7'(step_r);
  assign carry = rs >= nsamp;

  tcr_qsine u_qsine (
    .phase (ph),
    .value (wave)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      smp_valid <= 1'b0;
      smp_data  <= '0;
      rate      <= '0;
      nsamp     <= 7'd8;
      step_i    <= '0;
      step_r    <= '0;
      ph        <= '0;
      rem       <= '0;
      acc       <= '0;
    end else if (stop) begin
      active    <= 1'b0;
      smp_valid <= 1'b0;
    end else if (start) begin
      active    <= 1'b1;
      smp_valid <= 1'b0;
      rate      <= rate_of(fsi_n);
      nsamp     <= ns_n;
      step_i    <= stepi_n;
      step_r    <= stepr_n;
      ph        <= '0;
      rem       <= '0;
      acc       <= '0;
    end else if (active) begin
      if (wrap) begin
        acc       <= sum - AW'(CLK_HZ);
        smp_valid <= 1'b1;
        smp_data  <= wave;
        ph        <= ph + 6'(step_i) + 6'(carry);
        rem       <= carry ? (rs - nsamp) : rs;
      end else begin
        acc       <= sum;
        smp_valid <= 1'b0;
      end
    end else begin
      smp_valid <= 1'b0;
    end
  end

  AST_SMP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> active); // R4

  AST_SMP_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid); // R4

  AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (acc < AW'(CLK_HZ))); // R4

  AST_START_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> ((ph == '0) && (rem == '0))); // R5

  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (rem < nsamp)); // R5

endmodule

// File: rtl/tcr_recognizer.sv
module tcr_recognizer
  import tcr_pkg::*;
#(
  parameter int CLK_HZ   = 24_576_000,
  parameter int MEM_WAIT = 500,
  parameter int REG_AW   = 4,
  parameter int HDR0_IDX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic [REG_AW-1:0] reg_addr,
  input  logic [15:0]       reg_rdata,
  input  logic [15:0]       mem_result,
  output logic              hdr_we,
  output logic              hdr_sel,
  output logic [15:0]       hdr_wdata,
  output logic              tone_active,
  output logic              smp_valid,
  output logic [15:0]       smp_data
);

  localparam int CW = $clog2(MEM_WAIT + 1);
  localparam logic [NCMD-1:0] ALLOW_TONE = NCMD'(1) << CMD_QUIT;
  localparam logic [NCMD-1:0] ALLOW_IDLE = ~ALLOW_TONE;

  logic            take;
  logic [NCMD-1:0] allow;
  logic            hit;
  logic [1:0]      hit_cmd;
  logic [7:0]      hit_arg;
  logic            busy;
  logic [CW-1:0]   cnt;
  logic            dup_pend;
  logic            do_tone, do_quit, do_mem, do_dup;

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign out_data  = in_data;
  assign take      = in_valid && out_ready;
  assign allow     = tone_active ? ALLOW_TONE : ALLOW_IDLE;

  tcr_seq_match u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .din     (in_data),
    .allow   (allow),
    .hit     (hit),
    .hit_cmd (hit_cmd),
    .hit_arg (hit_arg)
  );

  assign do_tone = hit && !busy && (hit_cmd == CMD_TONE)
                   && (hit_arg >= TONE_ARG_MIN) && (hit_arg <= TONE_ARG_MAX);
  assign do_quit = hit && !busy && (hit_cmd == CMD_QUIT);
  assign do_mem  = hit && !busy && (hit_cmd == CMD_MEMCHK);
  assign do_dup  = hit && !busy && (hit_cmd == CMD_REGDUP)
                   && ({1'b0, hit_arg} < 9'(1 << REG_AW));

  tcr_tone #(.CLK_HZ(CLK_HZ)) u_tone (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (do_tone),
    .stop      (do_quit),
    .arg       (hit_arg),
    .active    (tone_active),
    .smp_valid (smp_valid),
    .smp_data  (smp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_we    <= 1'b0;
      hdr_sel   <= 1'b0;
      hdr_wdata <= '0;
      reg_addr  <= '0;
      dup_pend  <= 1'b0;
      busy      <= 1'b0;
      cnt       <= '0;
    end else begin
      hdr_we <= 1'b0;
      if (dup_pend) begin
        hdr_we    <= 1'b1;
        hdr_sel   <= (reg_addr == REG_AW'(HDR0_IDX));
        hdr_wdata <= reg_rdata;
        dup_pend  <= 1'b0;
      end
      if (busy) begin
        if (cnt == '0) begin
          hdr_we    <= 1'b1;
          hdr_sel   <= 1'b0;
          hdr_wdata <= mem_result;
          busy      <= 1'b0;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
      if (do_mem) begin
        busy <= 1'b1;
        cnt  <= CW'(MEM_WAIT - 1);
      end
      if (do_dup) begin
        reg_addr <= REG_AW'(hit_arg);
        dup_pend <= 1'b1;
      end
    end
  end

  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !tone_active); // R10

  AST_HDR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_we |=> !hdr_we); // R7

  AST_DUP_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_we && hdr_sel) |-> (reg_addr == REG_AW'(HDR0_IDX))); // R8

  AST_DUP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    dup_pend |=> hdr_we); // R8

endmodule

// File: tb/tcr_recognizer_test.sv
`timescale 1ns/1ps
module tcr_recognizer_test;

  localparam int CLK_HZ   = 441000;
  localparam int MEM_WAIT = 500;
  localparam int HDR0     = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic [3:0]  reg_addr;
  logic [15:0] reg_rdata;
  logic [15:0] mem_result = 16'h0000;
  logic        hdr_we, hdr_sel;
  logic [15:0] hdr_wdata;
  logic        tone_active, smp_valid;
  logic [15:0] smp_data;

  always #2 clk = ~clk;

  function automatic logic [15:0] rd_val(input logic [3:0] a);
    return 16'hA000 ^ {a, a, a, a};
  endfunction
  assign reg_rdata = rd_val(reg_addr);

  tcr_recognizer #(.CLK_HZ(CLK_HZ), .MEM_WAIT(MEM_WAIT), .REG_AW(4), .HDR0_IDX(HDR0)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .mem_result(mem_result),
    .hdr_we(hdr_we), .hdr_sel(hdr_sel), .hdr_wdata(hdr_wdata),
    .tone_active(tone_active), .smp_valid(smp_valid), .smp_data(smp_data)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // ---------------- reference model ----------------
  int  rates[9] = '{44100, 48000, 32000, 22050, 24000, 16000, 11025, 12000, 8000};
  int  mbuf[8];
  int  mlen = 0;
  bit  m_act = 0, m_sv = 0, m_busy = 0, m_cp = 0, m_we = 0, m_sel = 0;
  int  m_rate = 0, m_N = 8, m_acc = 0, m_idx = 0, m_sidx = 0, m_cnt = 0;
  int  m_ra = 0, m_wd = 0;

  // kinds: 0 tone, 1 quit, 2 memory check, 3 register copy
  function automatic int pat(input int k, input int i);
    int t[16] = '{'h53, 'hEF, 'h6E, -1, 'h45, 'h78, 'h69, 'h74,
                  'h4D, 'hEA, 'h6D, 'h54, 'h53, 'h70, 'hEE, -1};
    if (i >= 4) return 0;
    return t[k*4 + i];
  endfunction

  function automatic bit fits(input int k, input int n, input bit act);
    if (act != (k == 1)) return 0;
    for (int i = 0; i < n; i++)
      if (pat(k, i) >= 0 && pat(k, i) != mbuf[i]) return 0;
    return 1;
  endfunction

  function automatic int which(input int n, input bit act);
    for (int k = 0; k < 4; k++) if (fits(k, n, act)) return k;
    return -1;
  endfunction

  task automatic model_edge();
    bit act0, busy0;
    int sum, k;
    act0 = m_act; busy0 = m_busy;
    m_we = 0;
    if (m_cp) begin m_we = 1; m_sel = (m_ra == HDR0); m_wd = rd_val(4'(m_ra)); m_cp = 0; end
    if (busy0) begin
      m_cnt--;
      if (m_cnt == 0) begin m_we = 1; m_sel = 0; m_wd = mem_result; m_busy = 0; end
    end
    m_sv = 0;
    if (act0) begin
      sum = m_acc + m_rate;
      if (sum >= CLK_HZ) begin
        m_sv = 1; m_sidx = m_idx; m_idx = (m_idx + 1) % m_N; m_acc = sum - CLK_HZ;
      end else m_acc = sum;
    end
    if (in_valid && out_ready) begin
      mbuf[mlen] = in_data; mlen++;
      if (which(mlen, act0) < 0) begin
        mbuf[0] = in_data; mlen = 1;
        if (which(1, act0) < 0) mlen = 0;
      end
      if (mlen == 8) begin
        k = which(8, act0); mlen = 0;
        if (!busy0) begin
          if (k == 0 && mbuf[3] >= 48 && mbuf[3] <= 119) begin
            m_act = 1; m_rate = rates[(mbuf[3]-48) % 9]; m_N = 8 * ((mbuf[3]-48) / 9 + 1);
            m_acc = 0; m_idx = 0; m_sv = 0;
          end else if (k == 1) begin
            m_act = 0; m_sv = 0;
          end else if (k == 2) begin
            m_busy = 1; m_cnt = MEM_WAIT;
          end else if (k == 3 && mbuf[3] < 16) begin
            m_ra = mbuf[3]; m_cp = 1;
          end
        end
      end
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    real r;
    int ev, ph;
    chk("R1", "pass-through", {in_ready, out_valid, out_data},
        {out_ready, in_valid, in_data});
    chk("R2 R6 R9", "tone_active", tone_active, m_act);
    chk("R3 R4", "smp_valid", smp_valid, m_sv);
    if (m_sv && smp_valid) begin
      ph = (m_sidx * 64) / m_N;
      r = 32767.0 * $sin(2.0 * 3.14159265358979 * ph / 64.0);
      ev = (r >= 0.0) ? int'(r + 0.5) : -int'(-r + 0.5);
      n_vec++;
      if ($signed(smp_data) > ev + 2 || $signed(smp_data) < ev - 2) begin
        n_bad++;
        $display("FAIL R3 R5 smp_data: actual %0d expected %0d at %0t", $signed(smp_data), ev, $time);
      end
    end
    chk("R7 R8 R9 R10", "hdr_we", hdr_we, m_we);
    if (m_we && hdr_we) begin
      chk("R7 R8", "hdr_sel", hdr_sel, m_sel);
      chk("R7 R8", "hdr_wdata", hdr_wdata, m_wd);
    end
    chk("R8", "reg_addr", reg_addr, m_ra);
  endtask

  always @(posedge clk) begin
    if (rst_n && !done) begin
      model_edge();
      #1;
      compare();
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input int b);
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'(b); out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic seq(input int b0, input int b1, input int b2, input int b3);
    put(b0); put(b1); put(b2); put(b3);
    repeat (4) put(0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(4);
    // R11: reset state
    chk("R11", "reset outputs",
        {tone_active, smp_valid, hdr_we, hdr_sel, hdr_wdata, smp_data, reg_addr},
        0);
    rst_n = 1'b1;
    idle(3);

    // R7: memory check, all pass
    mem_result = 16'h0000;
    seq('h4D, 'hEA, 'h6D, 'h54); idle(520);
    // R7 + R10: failing word; copy during wait is discarded
    mem_result = 16'h0124;
    seq('h4D, 'hEA, 'h6D, 'h54);
    seq('h53, 'h70, 'hEE, 3);
    idle(520);

    // R8: copies
    seq('h53, 'h70, 'hEE, 3);    idle(6);
    seq('h53, 'h70, 'hEE, HDR0); idle(6);
    seq('h53, 'h70, 'hEE, 'h20); idle(6);

    // R9: broken lead byte rechecked
    mem_result = 16'h8001;
    put('h4D); seq('h4D, 'hEA, 'h6D, 'h54); idle(520);
    put('h53); put('hEF); seq('h53, 'hEF, 'h6E, 47); idle(10);

    // R1 + R2: held byte inside a tone command, n = 62
    put('h53); put('hEF); put('h6E);
    @(negedge clk); in_valid = 1'b1; in_data = 8'hAA; out_ready = 1'b0;
    idle(3);
    in_valid = 1'b0; out_ready = 1'b1;
    put(62); repeat (4) put(0);
    idle(1000);
    // R6: other commands ignored while tone on
    seq('h4D, 'hEA, 'h6D, 'h54);
    seq('h53, 'h70, 'hEE, 5);
    idle(600);
    seq('h45, 'h78, 'h69, 'h74); idle(20);

    // R2: out-of-range parameters; R6: quit when idle
    seq('h53, 'hEF, 'h6E, 120); idle(10);
    seq('h45, 'h78, 'h69, 'h74); idle(10);

    // R3 R4 R5: range ends and a non-power-of-two period
    seq('h53, 'hEF, 'h6E, 48);  idle(300);
    seq('h45, 'h78, 'h69, 'h74); idle(10);
    seq('h53, 'hEF, 'h6E, 72);  idle(2000);
    seq('h45, 'h78, 'h69, 'h74); idle(10);
    seq('h53, 'hEF, 'h6E, 119); idle(3700);
    seq('h45, 'h78, 'h69, 'h74); idle(20);

    finish_run();
  end

endmodule